// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block turns the interrupt sources of a 16550-compatible serial port into a single interrupt request and a three-bit identification code that the host reads to learn why it was interrupted. It takes the enable mask, the current receive FIFO fill count, the four receiver error flags, the transmit-holding-empty status and the four modem change flags. It then reports the single most urgent enabled cause.

Line errors, modem changes and transmit-empty events are held in pending flags until the host performs the read that acknowledges them. Pending flags record events even while their enable bit is clear. The receive-data cause is instead a live comparison of the FIFO count against a trigger level. That level is chosen by a two-bit select, or is fixed at one byte when the FIFOs are off. Reading the identification code acknowledges the transmit-empty cause, but only while that cause is the one being reported.

Top module: `uart_int_ident`

## Requirements
- R1: After reset the identification code is 3'b001 and `irq` is 0.
- R2: Each cause is reported only while its enable bit is set: `ier[0]` receive data, `ier[1]` transmit holding empty, `ier[2]` line status, `ier[3]` modem status; with `ier` all zero `irq` stays 0.
- R3: Codes are 3'b110 line status, 3'b100 receive data, 3'b010 transmit holding empty, 3'b000 modem status and 3'b001 none. When several enabled causes are pending, the order of precedence is line status, then receive data, then transmit empty, then modem status.
- R4: `irq` is always the inverse of bit 0 of the identification code.
- R5: With `fifo_en`=1, `trig_sel` 2'b00, 2'b01, 2'b10 and 2'b11 give trigger levels of 1, 4, 8 and 14 bytes. The receive-data cause is present while `rx_level` is at or above the level and is gone once the count drops below it.
- R6: With `fifo_en`=0 the trigger level is 1 byte whatever `trig_sel` holds.
- R7: A line-status cause is raised one cycle after any bit of `line_err` changes from 0 to 1. It is held until a `lsr_rd` pulse, and a flag that stays at 1 does not raise it again.
- R8: A modem-status cause is raised one cycle after any bit of `modem_delta` changes from 0 to 1, and is held until a `msr_rd` pulse.
- R9: A transmit-empty cause is raised one cycle after `thr_empty` rises. An `iir_rd` pulse clears it only if code 3'b010 is being reported in that cycle; a read while a higher cause is reported leaves it pending.
- R10: The transmit-empty cause clears one cycle after `thr_empty` falls.
- R11: If a new event arrives in the same cycle as the read that would clear its cause, the cause stays pending.
- R12: Causes latched while disabled are reported as soon as their enable bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ier | input | 4 | Interrupt enable mask |
| fifo_en | input | 1 | FIFO mode enable |
| trig_sel | input | 2 | Receive trigger level select |
| rx_level | input | LVL_W | Receive FIFO fill count |
| line_err | input | 4 | Overrun, parity, framing, break flags |
| thr_empty | input | 1 | Transmit holding register empty |
| modem_delta | input | 4 | Modem status change flags |
| iir_rd | input | 1 | Identification register read strobe |
| lsr_rd | input | 1 | Line status register read strobe |
| msr_rd | input | 1 | Modem status register read strobe |
| iir_id | output | 3 | Identification code |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of actions can land in the same clock edge. The first is an acknowledging read together with a fresh event for the same cause: the bench pulses `lsr_rd` in the very cycle that a second error bit rises. It then expects code 3'b110 to survive the read and to vanish only after a later read. The second is an identification read taken while line status outranks a pending transmit-empty cause. The bench expects transmit-empty to reappear once the line cause is acknowledged. Around these cases the bench sweeps every pending-source mask against every enable mask, and every trigger select against every fill count, in both FIFO modes.

// File: rtl/uart_iid_pkg.sv
package uart_iid_pkg;

   localparam int NUM_SRC = 4;

   // enable-mask bit index of each source
   localparam int SRC_RX    = 0;
   localparam int SRC_THRE  = 1;
   localparam int SRC_LINE  = 2;
   localparam int SRC_MODEM = 3;

   typedef enum logic [2:0] {
      ID_MODEM  = 3'b000,
      ID_NONE   = 3'b001,
      ID_THRE   = 3'b010,
      ID_RXDATA = 3'b100,
      ID_LINE   = 3'b110
   } iid_code_e;

   // source found at a given precedence rank (0 = most urgent)
   function automatic int prio_src(input int rank);
      case (rank)
         0:       prio_src = SRC_LINE;
         1:       prio_src = SRC_RX;
         2:       prio_src = SRC_THRE;
         default: prio_src = SRC_MODEM;
      endcase
   endfunction

   function automatic logic [2:0] src_code(input int src);
      case (src)
         SRC_LINE:  src_code = ID_LINE;
         SRC_RX:    src_code = ID_RXDATA;
         SRC_THRE:  src_code = ID_THRE;
         default:   src_code = ID_MODEM;
      endcase
   endfunction

endpackage

// File: rtl/uart_iid_rx_trigger.sv
module uart_iid_rx_trigger #(
   parameter int LVL_W  = 5,
   parameter int TRIG_A = 1,
   parameter int TRIG_B = 4,
   parameter int TRIG_C = 8,
   parameter int TRIG_D = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fifo_en,
   input  logic [1:0]       trig_sel,
   input  logic [LVL_W-1:0] rx_level,
   output logic             rx_hit
);

   localparam int LVL_MAX = (1 << LVL_W) - 1;
   localparam logic [LVL_W-1:0] LVL_ONE = LVL_W'(1);
   localparam logic [LVL_W-1:0] TRIG_TAB [4] = '{
      LVL_W'(TRIG_A), LVL_W'(TRIG_B), LVL_W'(TRIG_C), LVL_W'(TRIG_D)
   };

   generate
      if (TRIG_A < 1 || TRIG_A > TRIG_B || TRIG_B > TRIG_C ||
          TRIG_C > TRIG_D || TRIG_D > LVL_MAX) begin : g_bad_trig
         $error("trigger levels must ascend from 1 and fit LVL_W bits");
      end
   endgenerate

   logic [LVL_W-1:0] thr;

   always_comb begin
      if (fifo_en) thr = TRIG_TAB[trig_sel];
      else         thr = LVL_ONE;
   end

   assign rx_hit = (rx_level >= thr);

   // R5
   empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_level == '0) |-> !rx_hit);

   // R6
   nofifo_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!fifo_en && rx_level != '0) |-> rx_hit);

endmodule

// File: rtl/uart_iid_cause_hold.sv
module uart_iid_cause_hold #(
   parameter int W        = 4,
   parameter bit EDGE_SET = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt,
   input  logic         clr,
   output logic         pend
);

   generate
      if (W < 1) begin : g_bad_w
         $error("cause width must be at least 1");
      end
   endgenerate

   logic set;

   generate
      if (EDGE_SET) begin : g_edge
         logic [W-1:0] evt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) evt_q <= '0;
            else        evt_q <= evt;
         end
         assign set = |(evt & ~evt_q);
      end else begin : g_level
         assign set = |evt;
      end
   endgenerate

   // a new event takes precedence over the acknowledge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pend <= 1'b0;
      else if (set) pend <= 1'b1;
      else if (clr) pend <= 1'b0;
   end

   // R11
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> pend);

   // R7
   ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set) |=> !pend);

endmodule

// File: rtl/uart_iid_prio_enc.sv
module uart_iid_prio_enc
   import uart_iid_pkg::*;
(
   input  logic [NUM_SRC-1:0] req,
   output logic [2:0]         code,
   output logic               any
);

   // walk from least to most urgent so the most urgent writes last
   always_comb begin
      code = ID_NONE;
      any  = 1'b0;
      for (int r = NUM_SRC - 1; r >= 0; r--) begin
         if (req[prio_src(r)]) begin
            code = src_code(prio_src(r));
            any  = 1'b1;
         end
      end
   end

endmodule

// File: rtl/uart_int_ident.sv
module uart_int_ident
   import uart_iid_pkg::*;
#(
   parameter int LVL_W    = 5,
   parameter int TRIG_A   = 1,
   parameter int TRIG_B   = 4,
   parameter int TRIG_C   = 8,
   parameter int TRIG_D   = 14,
   parameter bit ERR_EDGE = 1'b1,
   parameter bit MSR_EDGE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       ier,
   input  logic             fifo_en,
   input  logic [1:0]       trig_sel,
   input  logic [LVL_W-1:0] rx_level,
   input  logic [3:0]       line_err,
   input  logic             thr_empty,
   input  logic [3:0]       modem_delta,
   input  logic             iir_rd,
   input  logic             lsr_rd,
   input  logic             msr_rd,
   output logic [2:0]       iir_id,
   output logic             irq
);

   generate
      if (LVL_W < 2) begin : g_bad_lvl
         $error("LVL_W too small for a FIFO count");
      end
   endgenerate

   logic               rx_hit;
   logic               line_pend;
   logic               modem_pend;
   logic               thre_pend;
   logic               thre_ack;
   logic [NUM_SRC-1:0] raw;
   logic [NUM_SRC-1:0] req;
   logic [2:0]         code;
   logic               any;

   uart_iid_rx_trigger #(
      .LVL_W (LVL_W),
      .TRIG_A(TRIG_A),
      .TRIG_B(TRIG_B),
      .TRIG_C(TRIG_C),
      .TRIG_D(TRIG_D)
   ) u_trig (
      .clk     (clk),
      .rst_n   (rst_n),
      .fifo_en (fifo_en),
      .trig_sel(trig_sel),
      .rx_level(rx_level),
      .rx_hit  (rx_hit)
   );

   uart_iid_cause_hold #(.W(4), .EDGE_SET(ERR_EDGE)) u_line (
      .clk  (clk),
      .rst_n(rst_n),
      .evt  (line_err),
      .clr  (lsr_rd),
      .pend (line_pend)
   );

   uart_iid_cause_hold #(.W(4), .EDGE_SET(MSR_EDGE)) u_modem (
      .clk  (clk),
      .rst_n(rst_n),
      .evt  (modem_delta),
      .clr  (msr_rd),
      .pend (modem_pend)
   );

   // acknowledged by reading the code while it names this cause,
   // or withdrawn when the holding register fills again
   assign thre_ack = (iir_rd && code == ID_THRE) || !thr_empty;

   uart_iid_cause_hold #(.W(1), .EDGE_SET(1'b1)) u_thre (
      .clk  (clk),
      .rst_n(rst_n),
      .evt  (thr_empty),
      .clr  (thre_ack),
      .pend (thre_pend)
   );

   always_comb begin
      raw            = '0;
      raw[SRC_RX]    = rx_hit;
      raw[SRC_THRE]  = thre_pend;
      raw[SRC_LINE]  = line_pend;
      raw[SRC_MODEM] = modem_pend;
   end

   assign req = raw & ier;

   uart_iid_prio_enc u_enc (
      .req (req),
      .code(code),
      .any (any)
   );

   assign iir_id = code;
   assign irq    = any;

   // R4
   irq_matches_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq == !iir_id[0]);

   // R3
   line_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req[SRC_LINE] |-> iir_id == 3'b110);

   // R3
   modem_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iir_id == 3'b000) |-> (req == 4'b1000));

   // R2
   masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ier == 4'b0000) |-> !irq);

   // R9
   thre_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iir_rd && iir_id == 3'b010) |=> !thre_pend);

   // R10
   thre_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !thr_empty |=> !thre_pend);

endmodule

// File: tb/test_uart_int_ident.sv
module test_uart_int_ident;

   localparam int LVL_W = 5;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [3:0]       ier = '0;
   logic             fifo_en = 1'b0;
   logic [1:0]       trig_sel = '0;
   logic [LVL_W-1:0] rx_level = '0;
   logic [3:0]       line_err = '0;
   logic             thr_empty = 1'b0;
   logic [3:0]       modem_delta = '0;
   logic             iir_rd = 1'b0;
   logic             lsr_rd = 1'b0;
   logic             msr_rd = 1'b0;
   logic [2:0]       iir_id;
   logic             irq;

   int n_chk  = 0;
   int n_fail = 0;

   always #4ns clk = ~clk;

   uart_int_ident #(.LVL_W(LVL_W)) i_uart_int_ident (
      .clk        (clk),
      .rst_n      (rst_n),
      .ier        (ier),
      .fifo_en    (fifo_en),
      .trig_sel   (trig_sel),
      .rx_level   (rx_level),
      .line_err   (line_err),
      .thr_empty  (thr_empty),
      .modem_delta(modem_delta),
      .iir_rd     (iir_rd),
      .lsr_rd     (lsr_rd),
      .msr_rd     (msr_rd),
      .iir_id     (iir_id),
      .irq        (irq)
   );

   // active: bit0 rx, bit1 thre, bit2 line, bit3 modem
   function automatic logic [2:0] exp_code(input logic [3:0] active);
      if (active[2])      return 3'b110;
      else if (active[0]) return 3'b100;
      else if (active[1]) return 3'b010;
      else if (active[3]) return 3'b000;
      else                return 3'b001;
   endfunction

   task automatic check(input string req, input logic [2:0] exp);
      logic exp_irq;
      exp_irq = ~exp[0];
      n_chk++;
      if (iir_id !== exp || irq !== exp_irq) begin
         n_fail++;
         $display("FAIL %s: id=%b irq=%b expected id=%b irq=%b",
                  req, iir_id, irq, exp, exp_irq);
      end
   endtask

   // inputs change just after a falling edge; one rising edge per step
   task automatic step();
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; ier = '0; fifo_en = 1'b0; trig_sel = '0; rx_level = '0;
      line_err = '0; thr_empty = 1'b0; modem_delta = '0;
      iir_rd = 1'b0; lsr_rd = 1'b0; msr_rd = 1'b0;
      step();
      step();
      rst_n = 1'b1;
      step();
   endtask

   function automatic int trig_of(input logic fe, input logic [1:0] sel);
      if (!fe) return 1;
      case (sel)
         2'b00:   return 1;
         2'b01:   return 4;
         2'b10:   return 8;
         default: return 14;
      endcase
   endfunction

   initial begin
      #(8ns * 200000);
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
      $finish;
   end

   initial begin
      @(negedge clk);
      do_reset();
      ier = 4'hF;
      #1ns;
      // R1
      check("R1 reset state", 3'b001);

      // R2 R3 R4 R12: every pending mask against every enable mask
      for (int m = 0; m < 16; m++) begin
         for (int e = 0; e < 16; e++) begin
            logic [3:0] mm;
            logic [3:0] ee;
            mm = 4'(m);
            ee = 4'(e);
            do_reset();
            ier         = ee;
            rx_level    = mm[0] ? LVL_W'(1) : '0;
            thr_empty   = mm[1];
            line_err    = mm[2] ? 4'b0100 : 4'b0000;
            modem_delta = mm[3] ? 4'b0001 : 4'b0000;
            step();
            line_err    = '0;
            modem_delta = '0;
            check("R3 priority under mask (R2, R4)", exp_code(mm & ee));
            if (ee != 4'hF) begin
               ier = 4'hF;
               #1ns;
               check("R12 latched cause after enable", exp_code(mm));
            end
         end
      end

      // R5 R6: trigger level sweep
      do_reset();
      ier = 4'b0001;
      for (int fe = 0; fe < 2; fe++) begin
         for (int s = 0; s < 4; s++) begin
            for (int lv = 0; lv <= 16; lv++) begin
               fifo_en  = fe[0];
               trig_sel = 2'(s);
               rx_level = LVL_W'(lv);
               step();
               if (fe == 1)
                  check("R5 trigger level", (lv >= trig_of(1'b1, 2'(s))) ? 3'b100 : 3'b001);
               else
                  check("R6 fifo off level", (lv >= 1) ? 3'b100 : 3'b001);
            end
         end
      end

      // R7: held error flag does not re-raise after acknowledge
      do_reset();
      ier = 4'hF;
      line_err = 4'b1000;
      step();
      check("R7 line cause raised", 3'b110);
      lsr_rd = 1'b1;
      step();
      lsr_rd = 1'b0;
      step();
      check("R7 line cleared, flag still high", 3'b001);
      line_err = '0;
      step();

      // R11: new error in the acknowledge cycle
      line_err = 4'b0001;
      step();
      check("R11 first error", 3'b110);
      lsr_rd   = 1'b1;
      line_err = 4'b0011;
      step();
      lsr_rd = 1'b0;
      check("R11 cause survives same-cycle read", 3'b110);
      lsr_rd = 1'b1;
      step();
      lsr_rd = 1'b0;
      check("R11 cleared by later read", 3'b001);
      line_err = '0;
      step();

      // R8: modem cause
      modem_delta = 4'b0010;
      step();
      check("R8 modem cause raised", 3'b000);
      modem_delta = '0;
      step();
      check("R8 modem cause held", 3'b000);
      msr_rd = 1'b1;
      step();
      msr_rd = 1'b0;
      check("R8 modem cleared by read", 3'b001);

      // R9: identification read acknowledges transmit-empty
      thr_empty = 1'b1;
      step();
      check("R9 thre raised", 3'b010);
      iir_rd = 1'b1;
      step();
      iir_rd = 1'b0;
      check("R9 thre cleared by ident read", 3'b001);
      thr_empty = 1'b0;
      step();
      thr_empty = 1'b1;
      step();
      check("R9 thre raised again", 3'b010);
      line_err = 4'b0100;
      step();
      line_err = '0;
      check("R9 line outranks thre", 3'b110);
      iir_rd = 1'b1;
      step();
      iir_rd = 1'b0;
      check("R9 read while line reported", 3'b110);
      lsr_rd = 1'b1;
      step();
      lsr_rd = 1'b0;
      check("R9 thre still pending", 3'b010);

      // R10: holding register filled again
      thr_empty = 1'b0;
      step();
      check("R10 thre withdrawn", 3'b001);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule